// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This controller manages a direct-mapped line store that is treated as two halves, so that it keeps most of the conflict tolerance of a two-way cache while a hit in the expected place costs only one cycle. A read first probes the line chosen by the address index. If that probe misses, a second probe goes one cycle later to the partner line, whose index is the same with the most significant bit inverted. A match there is a slower pseudo-hit. When both probes miss, the controller fetches the word from lower memory.

Lines are one data word wide. Each line stores an identity made of the address tag plus the index MSB, so the line at the partner location can be told apart from a line that belongs there. After a pseudo-hit the two lines trade places, so the line that was just used becomes a fast hit. A refill writes the new line at the primary location and pushes the old primary line, if it was valid, into the partner location. Writes are passed through to memory as single words. A write updates any copy that is already cached and never allocates a line. Every read response carries an outcome code that performance counters can use.

Top module: `pac_ctrl`

## Requirements
- R1: After reset, every line is invalid, `req_ready` is 1, and `rsp_valid`, `mem_req_valid` and `mem_wr_valid` are 0. The first read of any address is a miss.
- R2: A read that matches the line at its primary index (address bits [IDX_W-1:0]) returns its data with `rsp_valid` in the cycle right after acceptance, with `rsp_kind` = 2'b01.
- R3: The partner index is the primary index with bit IDX_W-1 inverted. The stored identity includes that bit, so an address never matches a line whose address differs from it only in the index MSB.
- R4: A read that misses the primary line and matches the partner line responds two cycles after acceptance, with `rsp_kind` = 2'b10.
- R5: After a pseudo-hit the two lines are swapped. The next read of the same address is a fast hit, and the line that was displaced becomes a pseudo-hit.
- R6: A read that misses both lines raises `mem_req_valid` one cycle after its second probe (two cycles after acceptance), with `mem_req_addr` equal to the read address. Both are held until `mem_rsp_valid`. The response follows in the next cycle with `rsp_kind` = 2'b11 and the data from memory.
- R7: A refill places the new line at the primary index and moves a valid old primary line to the partner index. Whatever was held at the partner index is lost.
- R8: When the primary line was invalid at refill time, the line at the partner index is kept.
- R9: `req_ready` is 0 while a second probe or a refill is pending. A request presented while `req_ready` is 0 has no effect.
- R10: A write is passed through: `mem_wr_valid` pulses in the cycle after acceptance, carrying the write address and data. No response is produced. A cached copy at either location takes the new data, and a write miss allocates no line.
- R11: `rsp_kind` is 2'b00 whenever `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response pulse |
| rsp_kind | output | 2 | 01 fast hit, 10 pseudo-hit, 11 miss, 00 idle |
| rsp_rdata | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Refill request, held until served |
| mem_req_addr | output | ADDR_W | Refill word address |
| mem_rsp_valid | input | 1 | Refill data pulse |
| mem_rsp_data | input | DATA_W | Refill data |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The reads are ordered around one pair of partner indices. Repeating an address tells a fast hit from a pseudo-hit. Alternating two conflicting addresses shows the swap. A third address that differs from a cached one only in the index MSB shows that the identity includes that bit, and its refill shows the old primary line being pushed out and the partner line being lost. A second index pair is refilled with an empty primary line, which separates the keep-the-partner rule from the move rule. Writes to a line held at its partner location, to a line at its primary location and to an uncached address are each followed by a read, which separates update in place from non-allocation. A write presented during a refill shows that requests are ignored while busy.

// File: rtl/pac_pkg.sv
package pac_pkg;

    typedef enum logic [1:0] {
        HIT_NONE   = 2'b00,
        HIT_FAST   = 2'b01,
        HIT_PSEUDO = 2'b10,
        HIT_MISS   = 2'b11
    } hit_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_PROBE2 = 2'b01,
        ST_REFILL = 2'b10
    } ctl_state_e;

    function automatic logic is_idle(ctl_state_e s);
        return s == ST_IDLE;
    endfunction

endpackage

// File: rtl/pac_line_store.sv
module pac_line_store #(
    parameter int IDX_W   = 4,
    parameter int ENTRY_W = 46
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   rd_idx_a,
    input  logic [IDX_W-1:0]   rd_idx_b,
    output logic [ENTRY_W-1:0] rd_ent_a,
    output logic [ENTRY_W-1:0] rd_ent_b,
    input  logic               wr_en_a,
    input  logic [IDX_W-1:0]   wr_idx_a,
    input  logic [ENTRY_W-1:0] wr_ent_a,
    input  logic               wr_en_b,
    input  logic [IDX_W-1:0]   wr_idx_b,
    input  logic [ENTRY_W-1:0] wr_ent_b
);
    localparam int SETS = 1 << IDX_W;

    logic [ENTRY_W-1:0] lines [SETS];

    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (rst) begin
                lines[s] <= '0;
            end else if (wr_en_a && wr_idx_a == IDX_W'(s)) begin
                lines[s] <= wr_ent_a;
            end else if (wr_en_b && wr_idx_b == IDX_W'(s)) begin
                lines[s] <= wr_ent_b;
            end
        end
    end

    assign rd_ent_a = lines[rd_idx_a];
    assign rd_ent_b = lines[rd_idx_b];

endmodule

// File: rtl/pac_match.sv
module pac_match #(
    parameter int IDENT_W = 13
) (
    input  logic               line_valid,
    input  logic [IDENT_W-1:0] line_ident,
    input  logic [IDENT_W-1:0] probe_ident,
    output logic               hit
);
    assign hit = line_valid && (line_ident == probe_ident);
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    import pac_pkg::*;

    localparam int IDENT_W = ADDR_W - IDX_W + 1;
    localparam int ENTRY_W = 1 + IDENT_W + DATA_W;

    typedef struct packed {
        logic               valid;
        logic [IDENT_W-1:0] ident;
        logic [DATA_W-1:0]  data;
    } line_t;

    ctl_state_e        state;
    logic [ADDR_W-1:0] lat_addr;
    logic [ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]  prim_idx;
    logic [IDX_W-1:0]  part_idx;
    logic [IDENT_W-1:0] cur_ident;
    line_t             rd_prim;
    line_t             rd_part;
    logic              hit_prim;
    logic              hit_part;
    logic              accept;

    logic              wr_en_a, wr_en_b;
    logic [IDX_W-1:0]  wr_idx_a, wr_idx_b;
    line_t             wr_ent_a, wr_ent_b;

    hit_kind_e         kind_q;

    assign req_ready = is_idle(state);
    assign accept    = req_valid && req_ready;
    assign cur_addr  = is_idle(state) ? req_addr : lat_addr;
    assign prim_idx  = cur_addr[IDX_W-1:0];
    assign part_idx  = {~cur_addr[IDX_W-1], cur_addr[IDX_W-2:0]};
    assign cur_ident = cur_addr[ADDR_W-1:IDX_W-1];

    pac_line_store #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx_a (prim_idx),
        .rd_idx_b (part_idx),
        .rd_ent_a (rd_prim),
        .rd_ent_b (rd_part),
        .wr_en_a  (wr_en_a),
        .wr_idx_a (wr_idx_a),
        .wr_ent_a (wr_ent_a),
        .wr_en_b  (wr_en_b),
        .wr_idx_b (wr_idx_b),
        .wr_ent_b (wr_ent_b)
    );

    pac_match #(.IDENT_W(IDENT_W)) u_match_prim (
        .line_valid  (rd_prim.valid),
        .line_ident  (rd_prim.ident),
        .probe_ident (cur_ident),
        .hit         (hit_prim)
    );

    pac_match #(.IDENT_W(IDENT_W)) u_match_part (
        .line_valid  (rd_part.valid),
        .line_ident  (rd_part.ident),
        .probe_ident (cur_ident),
        .hit         (hit_part)
    );

    // Line store update selection
    always_comb begin
        wr_en_a  = 1'b0;
        wr_idx_a = prim_idx;
        wr_ent_a = rd_part;
        wr_en_b  = 1'b0;
        wr_idx_b = part_idx;
        wr_ent_b = rd_prim;
        unique case (state)
            ST_IDLE: begin
                if (accept && req_write) begin
                    if (hit_prim) begin
                        wr_en_a       = 1'b1;
                        wr_idx_a      = prim_idx;
                        wr_ent_a      = rd_prim;
                        wr_ent_a.data = req_wdata;
                    end else if (hit_part) begin
                        wr_en_a       = 1'b1;
                        wr_idx_a      = part_idx;
                        wr_ent_a      = rd_part;
                        wr_ent_a.data = req_wdata;
                    end
                end
            end
            ST_PROBE2: begin
                if (hit_part) begin
                    wr_en_a = 1'b1;
                    wr_en_b = 1'b1;
                end
            end
            ST_REFILL: begin
                if (mem_rsp_valid) begin
                    wr_en_a        = 1'b1;
                    wr_ent_a.valid = 1'b1;
                    wr_ent_a.ident = cur_ident;
                    wr_ent_a.data  = mem_rsp_data;
                    wr_en_b        = rd_prim.valid;
                end
            end
            default: ;
        endcase
    end

    // Sequencing and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            lat_addr      <= '0;
            rsp_valid     <= 1'b0;
            kind_q        <= HIT_NONE;
            rsp_rdata     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            mem_wr_valid  <= 1'b0;
            mem_wr_addr   <= '0;
            mem_wr_data   <= '0;
        end else begin
            rsp_valid    <= 1'b0;
            kind_q       <= HIT_NONE;
            mem_wr_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lat_addr <= req_addr;
                        if (req_write) begin
                            mem_wr_valid <= 1'b1;
                            mem_wr_addr  <= req_addr;
                            mem_wr_data  <= req_wdata;
                        end else if (hit_prim) begin
                            rsp_valid <= 1'b1;
                            kind_q    <= HIT_FAST;
                            rsp_rdata <= rd_prim.data;
                        end else begin
                            state <= ST_PROBE2;
                        end
                    end
                end
                ST_PROBE2: begin
                    if (hit_part) begin
                        rsp_valid <= 1'b1;
                        kind_q    <= HIT_PSEUDO;
                        rsp_rdata <= rd_part.data;
                        state     <= ST_IDLE;
                    end else begin
                        mem_req_valid <= 1'b1;
                        mem_req_addr  <= lat_addr;
                        state         <= ST_REFILL;
                    end
                end
                ST_REFILL: begin
                    if (mem_rsp_valid) begin
                        mem_req_valid <= 1'b0;
                        rsp_valid     <= 1'b1;
                        kind_q        <= HIT_MISS;
                        rsp_rdata     <= mem_rsp_data;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rsp_kind = kind_q;

endmodule

// File: rtl/pac_ctrl_chk.sv
module pac_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [DATA_W-1:0] mem_rsp_data,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [DATA_W-1:0] mem_wr_data
);
    p_kind_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_kind == 2'b00);

    p_fast_or_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=>
            ((rsp_valid && rsp_kind == 2'b01) || (!req_ready && !rsp_valid)));

    p_pseudo_after_probe_r4: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'b10) |-> $past(!req_ready && !mem_req_valid));

    p_refill_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_miss_data_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_rsp_valid) |=>
            (rsp_valid && rsp_kind == 2'b11 && rsp_rdata == $past(mem_rsp_data)));

    p_busy_in_refill_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_write_through_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=>
            (mem_wr_valid && mem_wr_addr == $past(req_addr)
             && mem_wr_data == $past(req_wdata) && !rsp_valid));

endmodule

bind pac_ctrl pac_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_wdata     (req_wdata),
    .rsp_valid     (rsp_valid),
    .rsp_kind      (rsp_kind),
    .rsp_rdata     (rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .mem_wr_valid  (mem_wr_valid),
    .mem_wr_addr   (mem_wr_addr),
    .mem_wr_data   (mem_wr_data)
);

// File: tb/pac_ctrl_bench.sv
`timescale 1ns/1ps
module pac_ctrl_bench;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 4;
    localparam int MEM_LAT = 3;
    localparam logic [1:0] K_FAST = 2'b01, K_PSEUDO = 2'b10, K_MISS = 2'b11;
    localparam logic [ADDR_W-1:0] GUARD = 16'h0003;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_req_valid, mem_wr_valid;
    logic [1:0] rsp_kind;
    logic [DATA_W-1:0] rsp_rdata, mem_wr_data;
    logic [ADDR_W-1:0] mem_req_addr, mem_wr_addr;
    logic mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    pac_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_pac_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_rdata(rsp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    typedef struct {
        logic [ADDR_W-1:0] addr;
        logic [1:0]        kind;
        logic [DATA_W-1:0] data;
        int                acc_edge;
    } exp_t;

    exp_t sb[$];
    logic [DATA_W-1:0] bmem [int];
    int n_chk = 0, n_bad = 0, cyc = 0, mcnt = 0, kind_noise = 0;
    bit stray_wr = 0, done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] mem_read(logic [ADDR_W-1:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return {a, ~a};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(logic [1:0] k);
        return (k == K_FAST) ? "R2" : (k == K_PSEUDO) ? "R4" : "R6";
    endfunction

    // Monitor, scoreboard and memory model
    always @(negedge clk) begin
        if (!rst) begin
            if (!rsp_valid && rsp_kind != 2'b00) kind_noise++;
            if (mem_wr_valid && mem_wr_addr == GUARD) stray_wr = 1;
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R10", "unexpected response", 64'(rsp_kind), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_kind == e.kind, tag_of(e.kind), "kind", 64'(rsp_kind), 64'(e.kind));
                    chk(rsp_rdata == e.data, tag_of(e.kind), "data", 64'(rsp_rdata), 64'(e.data));
                    if (e.kind == K_MISS)
                        chk(mem_rsp_valid == 1'b1, "R6", "rsp after mem data", 64'(mem_rsp_valid), 64'd1);
                    else
                        chk(cyc - e.acc_edge + 1 == ((e.kind == K_FAST) ? 1 : 2), tag_of(e.kind),
                            "latency", 64'(cyc - e.acc_edge + 1), 64'((e.kind == K_FAST) ? 1 : 2));
                end
            end
            if (mem_rsp_valid) begin
                mem_rsp_valid = 1'b0;
                mcnt = 0;
            end else if (mem_req_valid) begin
                if (mcnt == 0 && sb.size() > 0) begin
                    chk(cyc == sb[0].acc_edge + 1, "R6", "refill request cycle",
                        64'(cyc), 64'(sb[0].acc_edge + 1));
                    chk(mem_req_addr == sb[0].addr, "R6", "refill address",
                        64'(mem_req_addr), 64'(sb[0].addr));
                end
                mcnt++;
                if (mcnt == MEM_LAT) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem_read(mem_req_addr);
                end
            end
        end
    end

    task automatic issue_read(logic [ADDR_W-1:0] a, logic [1:0] k);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.addr = a; e.kind = k; e.data = mem_read(a); e.acc_edge = cyc + 1;
        sb.push_back(e);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0 || !req_ready) @(negedge clk);
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, logic [1:0] k);
        issue_read(a, k);
        drain();
    endtask

    task automatic do_write(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        bmem[int'(a)] = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(mem_wr_valid == 1'b1, "R10", "write-through pulse", 64'(mem_wr_valid), 64'd1);
        chk(mem_wr_addr == a && mem_wr_data == d, "R10", "write-through addr/data",
            {16'd0, mem_wr_addr, mem_wr_data}, {16'd0, a, d});
    endtask

    localparam logic [ADDR_W-1:0] A = 16'h0012, B = 16'h0032, C = 16'h001A;
    localparam logic [ADDR_W-1:0] D = 16'h0005, E = 16'h000D, F = 16'h0007, G = 16'h0100;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !rsp_valid && !mem_req_valid && !mem_wr_valid, "R1", "reset outputs",
            {req_ready, rsp_valid, mem_req_valid, mem_wr_valid}, 64'b1000);
        do_read(A, K_MISS);      // R1 cold miss
        do_read(A, K_FAST);      // R2
        do_read(B, K_MISS);      // R7 A pushed to partner
        do_read(A, K_PSEUDO);    // R4 R3
        do_read(A, K_FAST);      // R5 swapped
        do_read(B, K_PSEUDO);    // R5 displaced line
        do_read(C, K_MISS);      // R7 A pushed, B lost
        do_read(B, K_MISS);      // R7 eviction visible
        do_read(A, K_PSEUDO);
        do_read(C, K_MISS);      // R3 index-MSB twin of A not matched
        do_read(A, K_MISS);
        do_read(B, K_PSEUDO);    // A now at partner
        do_write(A, 32'hA5A5_0001);   // R10 partner-location update
        do_read(A, K_PSEUDO);
        do_write(A, 32'hA5A5_0002);   // R10 primary update
        do_read(A, K_FAST);
        do_read(E, K_MISS);
        do_read(D, K_MISS);      // R8 empty primary, partner kept
        do_read(E, K_FAST);      // R8
        do_read(D, K_FAST);
        do_write(F, 32'h0F0F_0003);   // R10 no allocate
        do_read(F, K_MISS);
        issue_read(G, K_MISS);   // R9 write while busy
        chk(!req_ready, "R9", "busy after first-probe miss", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = GUARD; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        drain();
        chk(!stray_wr, "R9", "ignored write reached memory", 64'(stray_wr), 64'd0);
        do_read(GUARD, K_MISS);  // R9 no allocation or data change
        chk(kind_noise == 0, "R11", "kind nonzero while idle", 64'(kind_noise), 64'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule